// File: doc/BRIEF.md
# Hysteretic Field Threshold Switch

This block is the digital decision stage of a unipolar magnetic switch with a two-level supply-current output. Each clock it may receive a signed, already digitised field sample, qualified by a valid strobe. From a 6-bit trim code it derives an operate threshold: a base value plus the code times a fixed step. The release threshold sits a fixed, non-programmable hysteresis below it. A one-bit output then selects the high or the low supply-current level.

A strap selects one of two output polarities. In the normal variant, a field that rises past the operate threshold drives the output to low current. In the inverted variant the same event drives it to high current. The output is held at high current from reset until the first qualified sample has been judged. Positive sample values mean a south field, so a larger signed value is a stronger south field.

Top module: `hall_trip_stage`

## Requirements
- R1: From reset until the first qualified sample after reset has been evaluated, `icc_high` is 1.
- R2: The operate threshold is BASE + trim_code × STEP (trim_code 0 to 63, unsigned). The release threshold is that value minus HYST. All of these are compared as signed numbers.
- R3: Normal polarity (`invert_pol` = 0): from the released state, a qualified sample strictly greater than the operate threshold sets the operated state, and `icc_high` reads 0 one clock edge later.
- R4: Normal polarity: from the operated state, a qualified sample strictly less than the release threshold sets the released state, and `icc_high` reads 1 one edge later.
- R5: Inverted polarity (`invert_pol` = 1): the operated state gives `icc_high` = 1 and the released state gives `icc_high` = 0.
- R6: A qualified sample exactly equal to the operate or the release threshold does not change the state.
- R7: A qualified sample strictly between the two thresholds keeps the current state, whichever it is.
- R8: When `sample_vld` is 0, the sample is ignored and the state does not change.
- R9: The first qualified sample after reset sets the operated state if it is above the operate threshold. Otherwise, whether it is below the release threshold or between the thresholds, it sets the released state.
- R10: Samples are two's-complement. A strongly negative (north) sample never counts as above the operate threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_vld | input | 1 | Qualifies `field_in` for this cycle |
| field_in | input | FIELD_W | Signed field sample, positive = south |
| trim_code | input | TRIM_W | Unsigned operate-point trim code |
| invert_pol | input | 1 | Polarity strap: 0 normal, 1 inverted; change only in reset |
| icc_high | output | 1 | 1 selects the high supply-current level, 0 the low level |

## Verification
A qualified sample presented before a rising edge shows its result on `icc_high` right after that edge, because the comparison is combinational and there is a single state register behind it. Leaving reset costs two more edges, which is the delay of the reset synchroniser. The bench changes inputs on falling edges and reads `icc_high` on the following falling edge, half a period after the register updates. After each reset it waits for the synchroniser before it checks the boot level. It sweeps every trim code under both polarities. For each code it compares against thresholds computed from BASE, STEP and HYST, and it tests the exact threshold values together with one step on either side.

// File: rtl/hts_pkg.sv
package hts_pkg;

  typedef enum logic [1:0] {
    ST_BOOT     = 2'd0,
    ST_RELEASED = 2'd1,
    ST_OPERATED = 2'd2
  } hts_state_e;

endpackage

// File: rtl/hts_rst_sync.sv
module hts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hts_threshold_gen.sv
module hts_threshold_gen #(
  parameter int TRIM_W = 6,
  parameter int THR_W  = 18,
  parameter int BASE   = 10,
  parameter int STEP   = 5,
  parameter int HYST   = 12
) (
  input  logic [TRIM_W-1:0]       trim_code,
  output logic signed [THR_W-1:0] op_thr,
  output logic signed [THR_W-1:0] rel_thr
);

  localparam logic signed [THR_W-1:0] BaseC = THR_W'(BASE);
  localparam logic signed [THR_W-1:0] StepC = THR_W'(STEP);
  localparam logic signed [THR_W-1:0] HystC = THR_W'(HYST);

  logic signed [THR_W-1:0] code_ext;
  logic signed [THR_W-1:0] offset;

  always_comb begin
    code_ext = $signed({{(THR_W-TRIM_W){1'b0}}, trim_code});
    offset   = code_ext * StepC;
    op_thr   = BaseC + offset;
    rel_thr  = op_thr - HystC;
  end

endmodule

// File: rtl/hts_window_cmp.sv
module hts_window_cmp #(
  parameter int THR_W = 18
) (
  input  logic signed [THR_W-1:0] field_ext,
  input  logic signed [THR_W-1:0] op_thr,
  input  logic signed [THR_W-1:0] rel_thr,
  output logic                    above_op,
  output logic                    below_rel
);

  always_comb begin
    above_op  = field_ext > op_thr;
    below_rel = field_ext < rel_thr;
  end

endmodule

// File: rtl/hts_hyst_fsm.sv
module hts_hyst_fsm
  import hts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_vld,
  input  logic       above_op,
  input  logic       below_rel,
  input  logic       invert_pol,
  output hts_state_e state_q,
  output logic       icc_high
);

  hts_state_e state_d;
  logic       state_en;

  always_comb begin
    state_en = sample_vld;
    state_d  = state_q;
    unique case (state_q)
      ST_BOOT:     state_d = above_op ? ST_OPERATED : ST_RELEASED;
      ST_RELEASED: if (above_op)  state_d = ST_OPERATED;
      ST_OPERATED: if (below_rel) state_d = ST_RELEASED;
      default:     state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_BOOT;
    else if (state_en) state_q <= state_d;
  end

  always_comb begin
    if (state_q == ST_BOOT) icc_high = 1'b1;
    else                    icc_high = (state_q == ST_OPERATED) ^ ~invert_pol;
  end

endmodule

// File: rtl/hall_trip_stage.sv
module hall_trip_stage
  import hts_pkg::*;
#(
  parameter int FIELD_W = 10,
  parameter int TRIM_W  = 6,
  parameter int BASE    = 10,
  parameter int STEP    = 5,
  parameter int HYST    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld,
  input  logic [FIELD_W-1:0] field_in,
  input  logic [TRIM_W-1:0]  trim_code,
  input  logic               invert_pol,
  output logic               icc_high
);

  localparam int THR_W = FIELD_W + TRIM_W + 2;

  logic                    rst_sync_n;
  logic signed [THR_W-1:0] field_ext;
  logic signed [THR_W-1:0] op_thr;
  logic signed [THR_W-1:0] rel_thr;
  logic                    above_op;
  logic                    below_rel;
  hts_state_e              state_q;

  assign field_ext = $signed({{(THR_W-FIELD_W){field_in[FIELD_W-1]}}, field_in});

  hts_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hts_threshold_gen #(
    .TRIM_W (TRIM_W),
    .THR_W  (THR_W),
    .BASE   (BASE),
    .STEP   (STEP),
    .HYST   (HYST)
  ) u_thr (
    .trim_code (trim_code),
    .op_thr    (op_thr),
    .rel_thr   (rel_thr)
  );

  hts_window_cmp #(.THR_W(THR_W)) u_cmp (
    .field_ext (field_ext),
    .op_thr    (op_thr),
    .rel_thr   (rel_thr),
    .above_op  (above_op),
    .below_rel (below_rel)
  );

  hts_hyst_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sample_vld (sample_vld),
    .above_op   (above_op),
    .below_rel  (below_rel),
    .invert_pol (invert_pol),
    .state_q    (state_q),
    .icc_high   (icc_high)
  );

endmodule

// File: rtl/hts_checker.sv
module hts_checker
  import hts_pkg::*;
#(
  parameter int THR_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_vld,
  input  logic                    invert_pol,
  input  logic signed [THR_W-1:0] field_ext,
  input  logic signed [THR_W-1:0] op_thr,
  input  logic signed [THR_W-1:0] rel_thr,
  input  hts_state_e              state_q,
  input  logic                    icc_high
);

  logic armed;
  assign armed = sample_vld && (state_q != ST_BOOT);

  assert_trip_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !invert_pol && (field_ext > op_thr) |=> !icc_high);

  assert_release_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !invert_pol && (field_ext < rel_thr) |=> icc_high);

  assert_trip_inverted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && invert_pol && (field_ext > op_thr) |=> icc_high);

  assert_equal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ((field_ext == op_thr) || (field_ext == rel_thr)) |=> $stable(icc_high));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld |=> $stable(state_q));

  assert_boot_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld && (state_q == ST_BOOT) |=> icc_high);

endmodule

bind hall_trip_stage hts_checker #(.THR_W(THR_W)) u_hts_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sample_vld (sample_vld),
  .invert_pol (invert_pol),
  .field_ext  (field_ext),
  .op_thr     (op_thr),
  .rel_thr    (rel_thr),
  .state_q    (state_q),
  .icc_high   (icc_high)
);

// File: tb/hall_trip_stage_bench.sv
`timescale 1ns/1ps
module hall_trip_stage_bench;

  localparam int FIELD_W = 10;
  localparam int TRIM_W  = 6;
  localparam int BASE    = 10;
  localparam int STEP    = 5;
  localparam int HYST    = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sample_vld = 1'b0;
  logic [FIELD_W-1:0] field_in = '0;
  logic [TRIM_W-1:0]  trim_code = '0;
  logic               invert_pol = 1'b0;
  logic               icc_high;

  int checks = 0;
  int errors = 0;
  int mst = 0;   // 0 boot, 1 released, 2 operated
  int op_v = 0;
  int rel_v = 0;

  always #2.5 clk = ~clk;

  hall_trip_stage #(
    .FIELD_W(FIELD_W), .TRIM_W(TRIM_W), .BASE(BASE), .STEP(STEP), .HYST(HYST)
  ) u_hall_trip_stage (
    .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld), .field_in(field_in),
    .trim_code(trim_code), .invert_pol(invert_pol), .icc_high(icc_high)
  );

  function automatic logic exp_icc();
    if (mst == 0) return 1'b1;
    return (mst == 2) ? invert_pol : ~invert_pol;
  endfunction

  task automatic check(input logic expv, input string tag);
    checks++;
    if (icc_high !== expv) begin
      errors++;
      $display("FAIL %s icc_high actual=%0b expected=%0b code=%0d inv=%0b",
               tag, icc_high, expv, trim_code, invert_pol);
    end
  endtask

  task automatic do_reset(input logic inv, input int code);
    @(negedge clk);
    rst_n = 1'b0;
    sample_vld = 1'b0;
    invert_pol = inv;
    trim_code = TRIM_W'(code);
    op_v = BASE + code * STEP;
    rel_v = op_v - HYST;
    mst = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(exp_icc(), "R1 boot level");
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input int f, input logic v, input string tag);
    field_in = FIELD_W'(f);
    sample_vld = v;
    @(negedge clk);
    if (v) begin
      if (mst == 0)        mst = (f > op_v) ? 2 : 1;
      else if (f > op_v)   mst = 2;
      else if (f < rel_v)  mst = 1;
    end
    check(exp_icc(), tag);
    sample_vld = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < (1 << TRIM_W); c++) begin
        do_reset(p[0], c);
        apply(rel_v - 1, 1'b1, "R9 first sample below release");
        apply(op_v,      1'b1, "R6 equal operate holds");
        apply(op_v + 1,  1'b0, "R8 invalid sample ignored");
        apply(op_v + 1,  1'b1, p ? "R5 inverted trip" : "R3 normal trip R2");
        apply(rel_v,     1'b1, "R6 equal release holds");
        apply(rel_v + 1, 1'b1, "R7 between holds operated");
        apply(-300,      1'b0, "R8 invalid sample ignored");
        apply(rel_v - 1, 1'b1, p ? "R5 inverted release" : "R4 normal release R2");
        apply(rel_v + 1, 1'b1, "R7 between holds released");
        apply(-512,      1'b1, "R10 strong north no trip");
        do_reset(p[0], c);
        apply(op_v + 1,  1'b1, "R9 first sample above operate");
        do_reset(p[0], c);
        apply(rel_v + 1, 1'b1, "R9 first sample between");
        apply(op_v,      1'b1, "R6 equal operate after boot");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule